// File: doc/BRIEF.md
# Four-Input Latched Interrupt Merger

This block gathers four peripheral interrupt requests and presents them to an 8-bit CPU as one level-sensitive, active-low interrupt line. Each request line is active low and is brought into the clock domain through a two-flop synchronizer. A falling edge on a synchronized request sets that request's pending bit. The interrupt output stays low for as long as any pending bit is set.

The CPU reaches the block through its I/O port cycle: an 8-bit port address, separate write and read data buses, and active-low read, write and I/O-request strobes. The upper address nibble picks the device and the lower nibble picks the register. The block occupies device 4, register 0, which is port 0x40. A read returns the pending bits. A write clears exactly those pending bits whose data bit is written as zero, so the handler acknowledges one source without disturbing the others. The block latches edges rather than levels, so a source that keeps its line low does not re-raise the interrupt after the CPU has cleared it.

Top module: `irq_merge_ctl`

## Requirements
- R1: A falling edge on a synchronized request line (req_n bit i) sets pending bit i. A request driven low just after a clock edge is reflected on int_n on the fourth rising edge after that point, and not before. A low pulse one clock long is enough.
- R2: int_n is a registered output. It is low exactly when at least one pending bit was set at the previous edge, and it stays low with no pulsing while any bit remains pending.
- R3: The block responds only to an I/O cycle (iorq_n low) whose address has upper nibble 4 and lower nibble 0 (port 0x40). Writes to every other port, and writes to 0x40 with iorq_n high, leave the pending bits unchanged.
- R4: A read of port 0x40 (iorq_n and rd_n low) captures the pending bits into rdata at the next rising edge. Bit i of rdata is pending bit i, active high, and rdata bits 7:4 are zero. In every other cycle rdata is zero.
- R5: A write to port 0x40 clears each pending bit i whose wdata bit i is 0. The clear takes effect at the first rising edge of the write access and is applied once per access.
- R6: A pending bit whose wdata bit is written as 1 keeps its value.
- R7: A request line held low after its falling edge does not set its pending bit again once that bit has been cleared. Only a new falling edge sets it again.
- R8: When a new request edge and a clear for the same bit land on the same clock edge, the bit ends up set.
- R9: Synchronous active-high reset clears all pending bits, drives int_n high and drives rdata to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 4 | Peripheral interrupt requests, active low |
| port_addr | input | 8 | CPU I/O port address |
| wdata | input | 8 | CPU write data |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| iorq_n | input | 1 | CPU I/O request, active low |
| rdata | output | 8 | Registered read data |
| int_n | output | 1 | Interrupt to the CPU, active low |

## Verification
The bench builds the block with its default parameters: four sources, an 8-bit address with a 4-bit register field, device 4, register 0, and two synchronizer stages. With only four pending bits, it sweeps all 16 set patterns against all 16 clear masks and computes the expected value of every read and of int_n as `pattern & mask`. Because the address is 8 bits, the bench can write to all 255 foreign ports and confirm that none of them disturbs the pending state. The short synchronizer chain also makes the exact latency from a request edge to int_n, and the coincidence of a set and a clear on the same edge, easy to hit with direct stimulus.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

  // Decoded CPU access for the current cycle.
  typedef struct packed {
    logic rd;
    logic wr;
  } port_cmd_t;

  // Build the command from active-low strobes and an address hit.
  function automatic port_cmd_t decode_cmd(input logic hit, input logic iorq_n,
                                           input logic rd_n, input logic wr_n);
    port_cmd_t c;
    c.rd = hit & ~iorq_n & ~rd_n;
    c.wr = hit & ~iorq_n & ~wr_n;
    return c;
  endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  output logic fire
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  // Idle level of the line is high, so reset the chain to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], req_n};
      prev  <= chain[LAST];
    end
  end

  // A high-to-low transition at the synchronizer output.
  assign fire = prev & ~chain[LAST];

endmodule

// File: rtl/irq_port_decode.sv
module irq_port_decode
  import irq_merge_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          REG_BITS = 4,
  parameter int          DATA_W   = 8,
  parameter int          NSRC     = 4,
  parameter logic [31:0] DEV_SEL  = 32'h4,
  parameter logic [31:0] REG_SEL  = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              iorq_n,
  input  logic [NSRC-1:0]   pend,
  output logic [NSRC-1:0]   clr_mask,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEV_BITS = ADDR_W - REG_BITS;

  logic [DEV_BITS-1:0] dev_field;
  logic [REG_BITS-1:0] reg_field;
  logic                hit;
  port_cmd_t           cmd;
  logic                wr_q;
  logic                wr_first;
  logic [DATA_W-1:0]   rd_word;

  assign dev_field = port_addr[ADDR_W-1:REG_BITS];
  assign reg_field = port_addr[REG_BITS-1:0];
  assign hit = (dev_field == DEV_SEL[DEV_BITS-1:0]) &&
               (reg_field == REG_SEL[REG_BITS-1:0]);
  assign cmd = decode_cmd(hit, iorq_n, rd_n, wr_n);

  // A strobe may last several clocks: clear only on its first cycle.
  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b0;
    else     wr_q <= cmd.wr;
  end
  assign wr_first = cmd.wr & ~wr_q;

  // Clear bits written as zero.
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      clr_mask[i] = wr_first & ~wdata[i];
    end
  end

  // Zero-extend the pending vector into the data word.
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NSRC; i++) begin
      rd_word[i] = pend[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (cmd.rd) rdata <= rd_word;
    else             rdata <= '0;
  end

endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_v,
  input  logic [NSRC-1:0] clr_v,
  output logic [NSRC-1:0] pend,
  output logic            int_n
);

  // A set on the same edge as a clear takes precedence.
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) int_n <= 1'b1;
    else     int_n <= ~(|pend);
  end

endmodule

// File: rtl/irq_merge_ctl.sv
module irq_merge_ctl #(
  parameter int          NSRC        = 4,
  parameter int          ADDR_W      = 8,
  parameter int          REG_BITS    = 4,
  parameter int          DATA_W      = 8,
  parameter logic [31:0] DEV_SEL     = 32'h4,
  parameter logic [31:0] REG_SEL     = 32'h0,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   req_n,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              iorq_n,
  output logic [DATA_W-1:0] rdata,
  output logic              int_n
);

  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] clr_v;
  logic [NSRC-1:0] pend;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .req_n (req_n[g]),
      .fire  (set_v[g])
    );
  end

  irq_port_decode #(
    .ADDR_W   (ADDR_W),
    .REG_BITS (REG_BITS),
    .DATA_W   (DATA_W),
    .NSRC     (NSRC),
    .DEV_SEL  (DEV_SEL),
    .REG_SEL  (REG_SEL)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .port_addr (port_addr),
    .wdata     (wdata),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .iorq_n    (iorq_n),
    .pend      (pend),
    .clr_mask  (clr_v),
    .rdata     (rdata)
  );

  irq_pending_bank #(.NSRC(NSRC)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .set_v (set_v),
    .clr_v (clr_v),
    .pend  (pend),
    .int_n (int_n)
  );

endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk #(
  parameter int NSRC   = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   set_v,
  input logic [NSRC-1:0]   clr_v,
  input logic [NSRC-1:0]   pend,
  input logic              int_n,
  input logic [DATA_W-1:0] rdata
);

  // R2: the output level follows the pending state of the previous edge.
  assert_int_level_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int_n == !(|$past(pend))));

  // R4: the unused upper data bits always read zero.
  assert_rd_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:NSRC] == '0);

  // R6: with no set and no clear, the pending state holds.
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (set_v == '0 && clr_v == '0) |=> $stable(pend));

  // R8: every bit that sees an edge is pending afterwards, clear or not.
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((pend & $past(set_v)) == $past(set_v)));

  // R5: a cleared bit with no new edge is low afterwards.
  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_v != '0) |=> ((pend & $past(clr_v) & ~$past(set_v)) == '0));

  // R9: reset leaves an idle state.
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (pend == '0 && int_n && rdata == '0));

endmodule

bind irq_merge_ctl irq_merge_chk #(.NSRC(NSRC), .DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .set_v (set_v),
  .clr_v (clr_v),
  .pend  (pend),
  .int_n (int_n),
  .rdata (rdata)
);

// File: tb/test_irq_merge_ctl.sv
module test_irq_merge_ctl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req_n = 4'hF;
  logic [7:0] port_addr = 8'h00;
  logic [7:0] wdata = 8'hFF;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       iorq_n = 1'b1;
  logic [7:0] rdata;
  logic       int_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_merge_ctl i_irq_merge_ctl (
    .clk(clk), .rst(rst), .req_n(req_n), .port_addr(port_addr),
    .wdata(wdata), .rd_n(rd_n), .wr_n(wr_n), .iorq_n(iorq_n),
    .rdata(rdata), .int_n(int_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_req(input logic [3:0] m);
    req_n = ~m;
    tick(1);
    req_n = 4'hF;
    tick(4);
  endtask

  task automatic port_write(input logic [7:0] a, input logic [7:0] d, input logic io);
    port_addr = a; wdata = d; iorq_n = ~io; wr_n = 1'b0;
    tick(2);
    wr_n = 1'b1; iorq_n = 1'b1;
    tick(1);
  endtask

  task automatic port_read(input logic [7:0] a, output logic [7:0] v);
    port_addr = a; iorq_n = 1'b0; rd_n = 1'b0;
    tick(1);
    v = rdata;
    rd_n = 1'b1; iorq_n = 1'b1;
    tick(1);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    tick(3);
    // R9: state after reset
    check("R9 rdata at reset", rdata, 8'h00);
    check("R9 int_n at reset", {7'd0, int_n}, 8'h01);
    rst = 1'b0;
    tick(2);

    // R1: exact latency of one request
    req_n = 4'b1110;
    tick(3);
    check("R1 int_n before 4th edge", {7'd0, int_n}, 8'h01);
    tick(1);
    check("R1 int_n at 4th edge", {7'd0, int_n}, 8'h00);
    req_n = 4'hF;
    tick(2);
    port_read(8'h40, v);
    check("R1 R4 pending after request", v, 8'h01);
    check("R4 rdata idle", rdata, 8'h00);
    port_write(8'h40, 8'h00, 1'b1);

    // R5 R6 R2 R4: exhaustive set pattern x clear mask
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        port_write(8'h40, 8'h00, 1'b1);
        pulse_req(p[3:0]);
        port_read(8'h40, v);
        check("R1 R4 set pattern", v, {4'd0, p[3:0]});
        check("R2 int_n with pattern", {7'd0, int_n}, {7'd0, p[3:0] == 4'd0});
        port_write(8'h40, {4'hA, m[3:0]}, 1'b1);
        port_read(8'h40, v);
        check("R5 R6 after mask", v, {4'd0, p[3:0] & m[3:0]});
        check("R2 int_n after mask", {7'd0, int_n},
              {7'd0, (p[3:0] & m[3:0]) == 4'd0});
      end
    end

    // R3: foreign ports and non-I/O writes do not clear
    port_write(8'h40, 8'h00, 1'b1);
    pulse_req(4'hF);
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h40) begin
        port_addr = a[7:0]; wdata = 8'h00; iorq_n = 1'b0; wr_n = 1'b0;
        tick(1);
        wr_n = 1'b1; iorq_n = 1'b1;
      end
    end
    port_write(8'h40, 8'h00, 1'b0);
    port_read(8'h40, v);
    check("R3 foreign writes ignored", v, 8'h0F);
    port_read(8'h41, v);
    check("R3 R4 read of 0x41", v, 8'h00);
    port_read(8'h50, v);
    check("R3 R4 read of 0x50", v, 8'h00);
    port_read(8'h00, v);
    check("R3 R4 read of 0x00", v, 8'h00);

    // R7: held-low request does not refire after clear
    port_write(8'h40, 8'h00, 1'b1);
    req_n = 4'b1011;
    tick(6);
    port_write(8'h40, 8'h00, 1'b1);
    tick(4);
    port_read(8'h40, v);
    check("R7 held low no refire", v, 8'h00);
    check("R7 int_n stays high", {7'd0, int_n}, 8'h01);
    req_n = 4'hF;
    tick(3);
    req_n = 4'b1011;
    tick(5);
    req_n = 4'hF;
    port_read(8'h40, v);
    check("R7 new edge sets again", v, 8'h04);

    // R8: set and clear on the same edge
    port_write(8'h40, 8'h00, 1'b1);
    pulse_req(4'b0010);
    req_n = 4'b1110;
    tick(2);
    port_addr = 8'h40; wdata = 8'h00; iorq_n = 1'b0; wr_n = 1'b0;
    tick(1);
    wr_n = 1'b1; iorq_n = 1'b1; req_n = 4'hF;
    tick(2);
    port_read(8'h40, v);
    check("R8 set wins over clear", v, 8'h01);

    // R9: reset clears pending state
    pulse_req(4'b1000);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    check("R9 int_n after reset", {7'd0, int_n}, 8'h01);
    port_read(8'h40, v);
    check("R9 pending after reset", v, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule